// File: doc/BRIEF.md
# Emulator Byte Command Controller

This block sits between a serial byte link and a channel emulator. It reads one command byte at a time from a receive strobe. It keeps the noise scaling values that the emulator uses. It sends the emulator's two result counters back over a byte-wide transmit handshake. The serializer, the deserializer and the counters themselves are outside the block.

A load command brings in two 16-bit scaling values. These are held in shadow storage, and the emulator's scaling outputs do not change yet. A separate apply command does two things in the same cycle: it emits a one-cycle simulation reset and copies the shadow values onto the outputs. A read command takes a snapshot of both 64-bit counters and streams them out as a fixed 16-byte frame. While the frame is in flight, the block ignores any incoming bytes.

Top module: `emu_cmd_ctrl`

## Requirements
- R1: After reset, `snr_scale` and `pn_scale` are zero, and `sim_reset` and `tx_valid` are low.
- R2: Command byte 0x01 is followed by four data bytes: the SNR scale high byte, then its low byte, then the phase-noise scale high byte, then its low byte. Receiving these bytes does not change either scaling output.
- R3: Command byte 0x00 drives `sim_reset` high for exactly one cycle. In the same cycle, `snr_scale` and `pn_scale` take the most recently staged values.
- R4: The scaling outputs change only in a cycle where `sim_reset` is high. Applying again with no new load leaves them unchanged.
- R5: Command byte 0x02 starts a 16-byte reply. Bytes 0 to 7 are the bit counter, most significant byte first. Bytes 8 to 15 are the error counter, most significant byte first. `tx_valid` falls after the sixteenth byte.
- R6: Both counters are sampled in the cycle the 0x02 byte is accepted. Later changes on `bit_count` or `err_count` do not alter the frame being sent.
- R7: A reply byte advances only on a cycle with `tx_valid` and `tx_ready` both high. While `tx_ready` is low, `tx_data` is held.
- R8: Bytes received while a reply is in progress are discarded. They produce no pulse, and they do not alter the staged values.
- R9: A byte other than 0x00, 0x01 or 0x02 in idle is ignored. It produces no pulse, no reply and no change to the staged values.
- R10: The four data bytes after 0x01 are taken as data even when they equal a command code.
- R11: `rx_data` has no effect while `rx_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | One-cycle strobe: a received byte is present |
| rx_data | input | 8 | Received byte |
| tx_data | output | 8 | Reply byte to transmit |
| tx_valid | output | 1 | Reply byte is valid |
| tx_ready | input | 1 | Transmitter accepts the byte this cycle |
| snr_scale | output | 16 | Active SNR scaling value |
| pn_scale | output | 16 | Active phase-noise scaling value |
| sim_reset | output | 1 | One-cycle simulation reset pulse |
| bit_count | input | 64 | Processed-bit counter |
| err_count | input | 64 | Error counter |

## Verification
A table of scaling pairs is loaded and applied in turn. The pairs include all-ones and all-zero halves and values with only the top or bottom bit set, so that a byte-order swap or a swap between the SNR and phase-noise values shows up. Replies are read with `tx_ready` held high and again with stalls inserted, which separates correct holding of a byte from skipping or repeating one. The counter inputs change mid-frame to expose a missing snapshot. Command codes are sent as load data, during a reply, as unknown bytes and with `rx_valid` low; each case shows whether the decoder tracks its state correctly.

// File: rtl/emu_cmd_pkg.sv
package emu_cmd_pkg;
   localparam int BYTE_W = 8;
   localparam logic [BYTE_W-1:0] CMD_APPLY = 8'h00;
   localparam logic [BYTE_W-1:0] CMD_LOAD  = 8'h01;
   localparam logic [BYTE_W-1:0] CMD_READ  = 8'h02;

   typedef enum logic [0:0] {
      DEC_IDLE = 1'b0,
      DEC_LOAD = 1'b1
   } dec_state_t;
endpackage

// File: rtl/emu_cmd_decoder.sv
module emu_cmd_decoder
   import emu_cmd_pkg::*;
#(
   parameter int SCALE_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rx_valid,
   input  logic [BYTE_W-1:0]  rx_data,
   input  logic               busy,
   output logic               apply_req,
   output logic               read_req,
   output logic [SCALE_W-1:0] shadow_snr,
   output logic [SCALE_W-1:0] shadow_pn
);
   localparam int LOAD_BYTES = 2 * SCALE_W / BYTE_W;
   localparam int LCW        = $clog2(LOAD_BYTES);
   localparam int SH_W       = 2 * SCALE_W;

   dec_state_t       state;
   logic [LCW-1:0]   load_idx;
   logic [SH_W-1:0]  stage_q;
   logic             accept;

   assign accept     = rx_valid && !busy;
   assign shadow_snr = stage_q[SH_W-1 -: SCALE_W];
   assign shadow_pn  = stage_q[SCALE_W-1:0];

   always_comb begin
      apply_req = 1'b0;
      read_req  = 1'b0;
      if (accept && state == DEC_IDLE) begin
         apply_req = (rx_data == CMD_APPLY);
         read_req  = (rx_data == CMD_READ);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= DEC_IDLE;
         load_idx <= '0;
         stage_q  <= '0;
      end else if (accept) begin
         case (state)
            DEC_IDLE: begin
               if (rx_data == CMD_LOAD) begin
                  state    <= DEC_LOAD;
                  load_idx <= '0;
               end
            end
            DEC_LOAD: begin
               stage_q  <= {stage_q[SH_W-BYTE_W-1:0], rx_data};
               load_idx <= load_idx + LCW'(1);
               if (load_idx == LCW'(LOAD_BYTES - 1)) state <= DEC_IDLE;
            end
            default: state <= DEC_IDLE;
         endcase
      end
   end

   // R8: no staged-data shift while a reply is being sent
   assert_stage_frozen_in_reply_R8: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(stage_q));
   // R9: an unknown byte in idle leaves the decoder idle
   assert_unknown_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && state == DEC_IDLE && rx_data != CMD_LOAD) |=> state == DEC_IDLE);
endmodule

// File: rtl/emu_scale_regs.sv
module emu_scale_regs #(
   parameter int SCALE_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               apply_req,
   input  logic [SCALE_W-1:0] shadow_snr,
   input  logic [SCALE_W-1:0] shadow_pn,
   output logic [SCALE_W-1:0] snr_scale,
   output logic [SCALE_W-1:0] pn_scale,
   output logic               sim_reset
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         snr_scale <= '0;
         pn_scale  <= '0;
         sim_reset <= 1'b0;
      end else begin
         sim_reset <= apply_req;
         if (apply_req) begin
            snr_scale <= shadow_snr;
            pn_scale  <= shadow_pn;
         end
      end
   end

   // R3: the reset pulse lasts a single cycle
   assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      sim_reset |=> !sim_reset);
   // R4: active scaling moves only together with the reset pulse
   assert_scale_moves_with_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !($stable(snr_scale) && $stable(pn_scale)) |-> sim_reset);
endmodule

// File: rtl/emu_reply_stream.sv
module emu_reply_stream
   import emu_cmd_pkg::*;
#(
   parameter int CNT_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              read_req,
   input  logic [CNT_W-1:0]  bit_count,
   input  logic [CNT_W-1:0]  err_count,
   input  logic              tx_ready,
   output logic [BYTE_W-1:0] tx_data,
   output logic              tx_valid
);
   localparam int SNAP_W      = 2 * CNT_W;
   localparam int FRAME_BYTES = SNAP_W / BYTE_W;
   localparam int RCW         = $clog2(FRAME_BYTES + 1);

   logic [SNAP_W-1:0] snap_q;
   logic [RCW-1:0]    remain_q;
   logic              fire;

   assign tx_valid = (remain_q != '0);
   assign tx_data  = snap_q[SNAP_W-1 -: BYTE_W];
   assign fire     = tx_valid && tx_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         snap_q   <= '0;
         remain_q <= '0;
      end else if (read_req) begin
         snap_q   <= {bit_count, err_count};
         remain_q <= RCW'(FRAME_BYTES);
      end else if (fire) begin
         snap_q   <= {snap_q[SNAP_W-BYTE_W-1:0], {BYTE_W{1'b0}}};
         remain_q <= remain_q - RCW'(1);
      end
   end

   // R5: the byte counter never exceeds one frame
   assert_frame_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      remain_q <= RCW'(FRAME_BYTES));
   // R7: a stalled byte is held unchanged
   assert_hold_on_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
endmodule

// File: rtl/emu_cmd_ctrl.sv
module emu_cmd_ctrl
   import emu_cmd_pkg::*;
#(
   parameter int SCALE_W = 16,
   parameter int CNT_W   = 64
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rx_valid,
   input  logic [7:0]         rx_data,
   output logic [7:0]         tx_data,
   output logic               tx_valid,
   input  logic               tx_ready,
   output logic [SCALE_W-1:0] snr_scale,
   output logic [SCALE_W-1:0] pn_scale,
   output logic               sim_reset,
   input  logic [CNT_W-1:0]   bit_count,
   input  logic [CNT_W-1:0]   err_count
);
   generate
      if (SCALE_W % BYTE_W != 0 || SCALE_W < BYTE_W) begin : g_bad_scale
         $error("SCALE_W must be a nonzero multiple of the byte width");
      end
      if (CNT_W % BYTE_W != 0 || CNT_W < BYTE_W) begin : g_bad_cnt
         $error("CNT_W must be a nonzero multiple of the byte width");
      end
   endgenerate

   logic               apply_req;
   logic               read_req;
   logic [SCALE_W-1:0] shadow_snr;
   logic [SCALE_W-1:0] shadow_pn;

   emu_cmd_decoder #(.SCALE_W(SCALE_W)) u_dec (
      .clk        (clk),
      .rst_n      (rst_n),
      .rx_valid   (rx_valid),
      .rx_data    (rx_data),
      .busy       (tx_valid),
      .apply_req  (apply_req),
      .read_req   (read_req),
      .shadow_snr (shadow_snr),
      .shadow_pn  (shadow_pn)
   );

   emu_scale_regs #(.SCALE_W(SCALE_W)) u_scale (
      .clk        (clk),
      .rst_n      (rst_n),
      .apply_req  (apply_req),
      .shadow_snr (shadow_snr),
      .shadow_pn  (shadow_pn),
      .snr_scale  (snr_scale),
      .pn_scale   (pn_scale),
      .sim_reset  (sim_reset)
   );

   emu_reply_stream #(.CNT_W(CNT_W)) u_reply (
      .clk       (clk),
      .rst_n     (rst_n),
      .read_req  (read_req),
      .bit_count (bit_count),
      .err_count (err_count),
      .tx_ready  (tx_ready),
      .tx_data   (tx_data),
      .tx_valid  (tx_valid)
   );

   // R8: no reset pulse can appear while a reply is being sent
   assert_no_pulse_in_reply_R8: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> !sim_reset);
endmodule

// File: tb/emu_cmd_ctrl_test.sv
module emu_cmd_ctrl_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_valid = 1'b0;
   logic [7:0]  rx_data = 8'h00;
   logic [7:0]  tx_data;
   logic        tx_valid;
   logic        tx_ready = 1'b0;
   logic [15:0] snr_scale;
   logic [15:0] pn_scale;
   logic        sim_reset;
   logic [63:0] bit_count = 64'h0123_4567_89AB_CDEF;
   logic [63:0] err_count = 64'hFEDC_BA98_7654_3210;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   localparam logic [31:0] VEC [5] = '{
      32'h1234_ABCD, 32'hFFFF_0000, 32'h0000_FFFF, 32'h8001_7FFE, 32'hA55A_0F0F
   };

   always #(CLK_PERIOD/2) clk = ~clk;

   emu_cmd_ctrl uut (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
      .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
      .snr_scale(snr_scale), .pn_scale(pn_scale), .sim_reset(sim_reset),
      .bit_count(bit_count), .err_count(err_count)
   );

   task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic send_byte(input logic [7:0] b);
      @(negedge clk);
      rx_valid = 1'b1;
      rx_data  = b;
      @(negedge clk);
      rx_valid = 1'b0;
      rx_data  = 8'h00;
   endtask

   task automatic load(input logic [15:0] s, input logic [15:0] p);
      send_byte(8'h01);
      send_byte(s[15:8]);
      send_byte(s[7:0]);
      send_byte(p[15:8]);
      send_byte(p[7:0]);
   endtask

   task automatic apply_and_check(input logic [15:0] s, input logic [15:0] p, input string tag);
      send_byte(8'h00);
      check(sim_reset === 1'b1, {tag, " pulse high"}, 64'(sim_reset), 64'd1);
      check(snr_scale === s, {tag, " snr"}, 64'(snr_scale), 64'(s));
      check(pn_scale === p, {tag, " pn"}, 64'(pn_scale), 64'(p));
      @(negedge clk);
      check(sim_reset === 1'b0, {tag, " pulse one cycle"}, 64'(sim_reset), 64'd0);
   endtask

   task automatic read_frame(input logic [63:0] eb, input logic [63:0] ee, input bit stall, input string tag);
      logic [127:0] exp_f;
      exp_f = {eb, ee};
      for (int i = 0; i < 16; i++) begin
         if (stall) begin
            logic [7:0] held;
            held = tx_data;
            tx_ready = 1'b0;
            @(negedge clk);
            @(negedge clk);
            check(tx_data === held && tx_valid === 1'b1, {tag, " R7 hold"}, 64'(tx_data), 64'(held));
         end
         check(tx_valid === 1'b1, {tag, " valid"}, 64'(tx_valid), 64'd1);
         check(tx_data === exp_f[127-8*i -: 8], {tag, " byte"}, 64'(tx_data), 64'(exp_f[127-8*i -: 8]));
         tx_ready = 1'b1;
         @(negedge clk);
         tx_ready = 1'b0;
      end
      check(tx_valid === 1'b0, {tag, " end of frame"}, 64'(tx_valid), 64'd0);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [15:0] cur_s;
      logic [15:0] cur_p;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(snr_scale === 16'h0 && pn_scale === 16'h0, "R1 scale reset", {snr_scale, pn_scale}, 64'd0);
      check(sim_reset === 1'b0, "R1 pulse reset", 64'(sim_reset), 64'd0);
      check(tx_valid === 1'b0, "R1 tx reset", 64'(tx_valid), 64'd0);

      // R2/R3 table walk
      cur_s = 16'h0;
      cur_p = 16'h0;
      foreach (VEC[k]) begin
         load(VEC[k][31:16], VEC[k][15:0]);
         check(snr_scale === cur_s && pn_scale === cur_p, "R2 staged not visible",
               {snr_scale, pn_scale}, {cur_s, cur_p});
         check(sim_reset === 1'b0, "R2 no pulse on load", 64'(sim_reset), 64'd0);
         cur_s = VEC[k][31:16];
         cur_p = VEC[k][15:0];
         apply_and_check(cur_s, cur_p, "R3 apply");
      end

      // R4 reapply without load
      apply_and_check(cur_s, cur_p, "R4 reapply");

      // R5 plain read
      send_byte(8'h02);
      read_frame(64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 1'b0, "R5 frame");

      // R6 snapshot + R7 stalls
      send_byte(8'h02);
      bit_count = 64'h1111_2222_3333_4444;
      err_count = 64'h5555_6666_7777_8888;
      read_frame(64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 1'b1, "R6 snapshot");
      send_byte(8'h02);
      read_frame(64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888, 1'b0, "R5 new counts");

      // R8 bytes during reply discarded
      send_byte(8'h02);
      send_byte(8'h00);
      check(sim_reset === 1'b0, "R8 no pulse in reply", 64'(sim_reset), 64'd0);
      send_byte(8'h01);
      send_byte(8'hAA);
      send_byte(8'hBB);
      send_byte(8'hCC);
      send_byte(8'hDD);
      read_frame(64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888, 1'b0, "R8 frame intact");
      apply_and_check(cur_s, cur_p, "R8 staged untouched");

      // R9 unknown bytes
      send_byte(8'h55);
      check(sim_reset === 1'b0 && tx_valid === 1'b0, "R9 unknown 0x55", {sim_reset, tx_valid}, 64'd0);
      send_byte(8'hFF);
      check(sim_reset === 1'b0 && tx_valid === 1'b0, "R9 unknown 0xFF", {sim_reset, tx_valid}, 64'd0);
      apply_and_check(cur_s, cur_p, "R9 staged untouched");

      // R10 command codes as load data
      send_byte(8'h01);
      send_byte(8'h02);
      check(tx_valid === 1'b0, "R10 0x02 as data", 64'(tx_valid), 64'd0);
      send_byte(8'h00);
      check(sim_reset === 1'b0, "R10 0x00 as data", 64'(sim_reset), 64'd0);
      send_byte(8'h01);
      send_byte(8'h00);
      check(snr_scale === cur_s, "R10 outputs held", 64'(snr_scale), 64'(cur_s));
      cur_s = 16'h0200;
      cur_p = 16'h0100;
      apply_and_check(cur_s, cur_p, "R10 apply");

      // R11 rx_data without strobe
      @(negedge clk);
      rx_data = 8'h02;
      @(negedge clk);
      rx_data = 8'h00;
      @(negedge clk);
      check(sim_reset === 1'b0 && tx_valid === 1'b0, "R11 no strobe", {sim_reset, tx_valid}, 64'd0);
      rx_data = 8'h00;

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule